// File: doc/BRIEF.md
# Priority Mask Access Router

This block judges a privileged system-register access aimed at the interrupt priority mask. It takes the current exception level, the feature-present flags, the configuration of levels 2 and 3, the per-level register-enable bits, the trap and interrupt-routing controls, and the secure-debug qualifiers. From these it picks exactly one outcome: the access is undefined, trapped to level 2, trapped to level 3 (or monitor), redirected to the virtual copy of the mask, or allowed to reach the physical mask register.

A read and a write are judged the same way, so the block has a single request strobe. It only makes the decision. Moving the data is left to the surrounding register file and the exception logic. The outcome comes out as five discrete flags and as a one-hot result code. A syndrome byte goes with a level-2 trap. With the default `REG_OUT=1` the decision is registered, so it appears one clock after the request.

Top module: `pmr_access_router`

## Requirements
- R1: While a request is active, the outcome is undefined whenever the 32-bit level-1 feature flag or the interrupt-interface feature flag is 0, whatever the other inputs are.
- R2: A request from exception level 0 (`el_i`=0) is undefined.
- R3: At level 1 the first matching rule wins, in this order:
  - (a) the debug-priority qualifier is set while level-3 routing is in effect: undefined;
  - (b) the level-2 group trap is set: trap to level 2;
  - (c) the level-1 enable is 0: undefined;
  - (d) the level-2 common trap is set: trap to level 2;
  - (e) the level-2 FIQ or IRQ routing bit is set: virtual copy;
  - (f) level-3 routing is in effect: trap to level 3;
  - (g) otherwise: physical register.
- R4: Level-3 routing is in effect only when both level-3 FIQ and IRQ routing bits are 1. When level 3 runs in the 32-bit state it is in effect only outside monitor mode. When the debug-undefine flag is 1, a level-3 routing trap becomes undefined.
- R5: With level 3 absent (`has_el3_i`=0), no level-3 check fires and no trap to level 3 is produced.
- R6: Unless level 2 is both implemented and enabled, the level-2 trap and redirect checks are skipped. No trap to level 2 and no virtual access result.
- R7: For each request exactly one outcome flag is 1. With no request all flags and the code are 0. `code_o` bit 0 means physical, bit 1 virtual, bit 2 trap to level 3, bit 3 trap to level 2, and bit 4 undefined. Each bit equals its flag output.
- R8: At level 3 the outcome is undefined when the level-3 enable is 0, and physical otherwise.
- R9: `syndrome_o` is 0x03 exactly when the outcome is a trap to level 2, and 0x00 otherwise.
- R10: At level 2 the first matching rule wins, in this order:
  - the debug-priority undefine of R3(a);
  - the level-2 enable is 0: undefined;
  - level-3 routing trap (R4);
  - otherwise: physical register.
- R11: With `REG_OUT`=1 all outputs reflect the request of the previous clock. Asynchronous reset clears them to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Access request (read or write) |
| el_i | input | 2 | Current exception level 0..3 |
| has_a32_el1_i | input | 1 | 32-bit level-1 feature present |
| has_irq_if_i | input | 1 | Interrupt interface feature present |
| has_el2_i | input | 1 | Level 2 implemented |
| has_el3_i | input | 1 | Level 3 implemented |
| el2_en_i | input | 1 | Level 2 enabled |
| el3_a32_i | input | 1 | Level 3 runs in 32-bit state |
| sre_el1_i | input | 1 | Level-1 register enable |
| sre_el2_i | input | 1 | Level-2 register enable |
| sre_el3_i | input | 1 | Level-3 register enable |
| l2_grp_trap_i | input | 1 | Level-2 trap for this register group |
| l2_cmn_trap_i | input | 1 | Level-2 common-register trap |
| l2_fiq_route_i | input | 1 | Level-2 FIQ routing |
| l2_irq_route_i | input | 1 | Level-2 IRQ routing |
| l3_fiq_route_i | input | 1 | Level-3 FIQ routing |
| l3_irq_route_i | input | 1 | Level-3 IRQ routing |
| dbg_undef_prio_i | input | 1 | Secure-debug undefine, high-priority form |
| dbg_undef_i | input | 1 | Secure-debug undefine applied to level-3 traps |
| monitor_i | input | 1 | Processor in monitor mode |
| valid_o | output | 1 | Outcome valid |
| undef_o | output | 1 | Undefined outcome |
| trap_el2_o | output | 1 | Trap to level 2 |
| trap_el3_o | output | 1 | Trap to level 3 / monitor |
| virt_o | output | 1 | Access goes to virtual copy |
| phys_o | output | 1 | Access goes to physical register |
| code_o | output | 5 | One-hot outcome code |
| syndrome_o | output | 8 | Syndrome for a level-2 trap |

## Verification
The bench goes after the places where two rules compete.
- The group trap against a zero level-1 enable: a design that tested the enable first would report undefined where a trap is owed.
- The debug-priority undefine against every level-2 trap: getting this wrong lets a trap escape that should have been undefined.
- Virtual redirection against the level-3 routing trap: an inverted order sends guest accesses to level 3.
- The monitor-mode exemption with a 32-bit level 3: a design that dropped it traps from monitor mode.
- Levels 2 and 3 absent or disabled: a design that ignored the presence gates raises traps to missing levels.

// File: rtl/pmr_route_pkg.sv
package pmr_route_pkg;

  localparam int unsigned NUM_OC = 5;
  localparam int unsigned SYND_W = 8;

  typedef enum logic [2:0] {
    OC_PHYS  = 3'd0,
    OC_VIRT  = 3'd1,
    OC_TRAP3 = 3'd2,
    OC_TRAP2 = 3'd3,
    OC_UNDEF = 3'd4
  } outcome_e;

  typedef struct packed {
    logic has_a32_el1;
    logic has_irq_if;
    logic has_el2;
    logic has_el3;
    logic el2_en;
    logic el3_a32;
    logic sre_el1;
    logic sre_el2;
    logic sre_el3;
    logic l2_grp_trap;
    logic l2_cmn_trap;
    logic l2_fiq;
    logic l2_irq;
    logic l3_fiq;
    logic l3_irq;
    logic dbg_undef_prio;
    logic dbg_undef;
    logic monitor;
  } acc_ctx_t;

  function automatic logic [NUM_OC-1:0] oc_code(outcome_e oc);
    return NUM_OC'(1) << oc;
  endfunction

endpackage

// File: rtl/pmr_l3_route.sv
module pmr_l3_route
  import pmr_route_pkg::*;
(
  input  acc_ctx_t ctx_i,
  output logic     route_o,
  output logic     prio_undef_o,
  output outcome_e trap_oc_o
);
  logic mon_exempt;

  // a 32-bit level 3 leaves monitor mode alone
  assign mon_exempt   = ctx_i.el3_a32 & ctx_i.monitor;
  assign route_o      = ctx_i.has_el3 & ctx_i.l3_fiq & ctx_i.l3_irq & ~mon_exempt;
  assign prio_undef_o = route_o & ctx_i.dbg_undef_prio;
  assign trap_oc_o    = ctx_i.dbg_undef ? OC_UNDEF : OC_TRAP3;

endmodule

// File: rtl/pmr_level_chain.sv
module pmr_level_chain
  import pmr_route_pkg::*;
#(
  parameter int unsigned LEVEL = 1
) (
  input  acc_ctx_t ctx_i,
  input  logic     l3_route_i,
  input  logic     l3_prio_undef_i,
  input  outcome_e l3_trap_oc_i,
  output outcome_e oc_o
);
  logic l2_on;
  logic unused_ctx;

  assign l2_on      = ctx_i.has_el2 & ctx_i.el2_en;
  assign unused_ctx = ^ctx_i;

  generate
    if (LEVEL == 1) begin : g_el1
      always_comb begin
        if (l3_prio_undef_i)                            oc_o = OC_UNDEF;
        else if (l2_on && ctx_i.l2_grp_trap)            oc_o = OC_TRAP2;
        else if (!ctx_i.sre_el1)                        oc_o = OC_UNDEF;
        else if (l2_on && ctx_i.l2_cmn_trap)            oc_o = OC_TRAP2;
        else if (l2_on && (ctx_i.l2_fiq || ctx_i.l2_irq)) oc_o = OC_VIRT;
        else if (l3_route_i)                            oc_o = l3_trap_oc_i;
        else                                            oc_o = OC_PHYS;
      end
    end else if (LEVEL == 2) begin : g_el2
      logic unused_l2;
      assign unused_l2 = l2_on;
      always_comb begin
        if (l3_prio_undef_i)     oc_o = OC_UNDEF;
        else if (!ctx_i.sre_el2) oc_o = OC_UNDEF;
        else if (l3_route_i)     oc_o = l3_trap_oc_i;
        else                     oc_o = OC_PHYS;
      end
    end else begin : g_el3
      logic unused_l3;
      assign unused_l3 = l2_on ^ l3_route_i ^ l3_prio_undef_i ^ (^l3_trap_oc_i);
      always_comb begin
        oc_o = ctx_i.sre_el3 ? OC_PHYS : OC_UNDEF;
      end
    end
  endgenerate

endmodule

// File: rtl/pmr_out_stage.sv
module pmr_out_stage #(
  parameter bit          REG_OUT = 1'b1,
  parameter int unsigned WIDTH   = 14
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  generate
    if (REG_OUT) begin : g_reg
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) q_o <= '0;
        else         q_o <= d_i;
      end
    end else begin : g_comb
      logic unused_clk;
      assign unused_clk = clk_i ^ rst_ni;
      assign q_o        = d_i;
    end
  endgenerate

endmodule

// File: rtl/pmr_access_router.sv
module pmr_access_router
  import pmr_route_pkg::*;
#(
  parameter bit          REG_OUT   = 1'b1,
  parameter logic [7:0]  TRAP_SYND = 8'h03
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       req_i,
  input  logic [1:0] el_i,
  input  logic       has_a32_el1_i,
  input  logic       has_irq_if_i,
  input  logic       has_el2_i,
  input  logic       has_el3_i,
  input  logic       el2_en_i,
  input  logic       el3_a32_i,
  input  logic       sre_el1_i,
  input  logic       sre_el2_i,
  input  logic       sre_el3_i,
  input  logic       l2_grp_trap_i,
  input  logic       l2_cmn_trap_i,
  input  logic       l2_fiq_route_i,
  input  logic       l2_irq_route_i,
  input  logic       l3_fiq_route_i,
  input  logic       l3_irq_route_i,
  input  logic       dbg_undef_prio_i,
  input  logic       dbg_undef_i,
  input  logic       monitor_i,
  output logic       valid_o,
  output logic       undef_o,
  output logic       trap_el2_o,
  output logic       trap_el3_o,
  output logic       virt_o,
  output logic       phys_o,
  output logic [4:0] code_o,
  output logic [7:0] syndrome_o
);
  localparam int unsigned OUT_W = 1 + NUM_OC + SYND_W;

  acc_ctx_t ctx;
  logic     l3_route, l3_prio_undef;
  outcome_e l3_trap_oc;
  outcome_e lvl_oc [1:3];
  outcome_e sel_oc;

  logic [NUM_OC-1:0] code_d;
  logic [SYND_W-1:0] synd_d;
  logic [OUT_W-1:0]  out_d, out_q;

  assign ctx = '{
    has_a32_el1:    has_a32_el1_i,
    has_irq_if:     has_irq_if_i,
    has_el2:        has_el2_i,
    has_el3:        has_el3_i,
    el2_en:         el2_en_i,
    el3_a32:        el3_a32_i,
    sre_el1:        sre_el1_i,
    sre_el2:        sre_el2_i,
    sre_el3:        sre_el3_i,
    l2_grp_trap:    l2_grp_trap_i,
    l2_cmn_trap:    l2_cmn_trap_i,
    l2_fiq:         l2_fiq_route_i,
    l2_irq:         l2_irq_route_i,
    l3_fiq:         l3_fiq_route_i,
    l3_irq:         l3_irq_route_i,
    dbg_undef_prio: dbg_undef_prio_i,
    dbg_undef:      dbg_undef_i,
    monitor:        monitor_i
  };

  pmr_l3_route i_l3_route (
    .ctx_i       (ctx),
    .route_o     (l3_route),
    .prio_undef_o(l3_prio_undef),
    .trap_oc_o   (l3_trap_oc)
  );

  generate
    for (genvar lv = 1; lv <= 3; lv++) begin : g_lvl
      pmr_level_chain #(.LEVEL(lv)) i_chain (
        .ctx_i          (ctx),
        .l3_route_i     (l3_route),
        .l3_prio_undef_i(l3_prio_undef),
        .l3_trap_oc_i   (l3_trap_oc),
        .oc_o           (lvl_oc[lv])
      );
    end
  endgenerate

  // feature gate and level 0 come before any per-level chain
  always_comb begin
    if (!(has_a32_el1_i && has_irq_if_i)) begin
      sel_oc = OC_UNDEF;
    end else begin
      unique case (el_i)
        2'd1:    sel_oc = lvl_oc[1];
        2'd2:    sel_oc = lvl_oc[2];
        2'd3:    sel_oc = lvl_oc[3];
        default: sel_oc = OC_UNDEF;
      endcase
    end
  end

  assign code_d = req_i ? oc_code(sel_oc) : '0;
  assign synd_d = (req_i && sel_oc == OC_TRAP2) ? TRAP_SYND : '0;
  assign out_d  = {req_i, code_d, synd_d};

  pmr_out_stage #(.REG_OUT(REG_OUT), .WIDTH(OUT_W)) i_out (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (out_d),
    .q_o   (out_q)
  );

  assign valid_o    = out_q[OUT_W-1];
  assign code_o     = out_q[SYND_W +: NUM_OC];
  assign syndrome_o = out_q[SYND_W-1:0];
  assign phys_o     = code_o[OC_PHYS];
  assign virt_o     = code_o[OC_VIRT];
  assign trap_el3_o = code_o[OC_TRAP3];
  assign trap_el2_o = code_o[OC_TRAP2];
  assign undef_o    = code_o[OC_UNDEF];

endmodule

// File: rtl/pmr_access_router_chk.sv
module pmr_access_router_chk #(
  parameter bit         REG_OUT   = 1'b1,
  parameter logic [7:0] TRAP_SYND = 8'h03
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       req_i,
  input logic [1:0] el_i,
  input logic       has_a32_el1_i,
  input logic       has_irq_if_i,
  input logic       has_el2_i,
  input logic       has_el3_i,
  input logic       el2_en_i,
  input logic       valid_o,
  input logic       undef_o,
  input logic       trap_el2_o,
  input logic       trap_el3_o,
  input logic       virt_o,
  input logic       phys_o,
  input logic [4:0] code_o,
  input logic [7:0] syndrome_o
);
  logic       d_req, d_feat, d_l2on, d_l3;
  logic [1:0] d_el;
  logic [4:0] flags;

  assign flags = {undef_o, trap_el2_o, trap_el3_o, virt_o, phys_o};

  generate
    if (REG_OUT) begin : g_dly
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          d_req <= 1'b0; d_feat <= 1'b0; d_l2on <= 1'b0; d_l3 <= 1'b0; d_el <= '0;
        end else begin
          d_req  <= req_i;
          d_feat <= has_a32_el1_i & has_irq_if_i;
          d_l2on <= has_el2_i & el2_en_i;
          d_l3   <= has_el3_i;
          d_el   <= el_i;
        end
      end
    end else begin : g_now
      assign d_req  = req_i;
      assign d_feat = has_a32_el1_i & has_irq_if_i;
      assign d_l2on = has_el2_i & el2_en_i;
      assign d_l3   = has_el3_i;
      assign d_el   = el_i;
    end
  endgenerate

  a_r7_one_outcome: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> $onehot(flags));
  a_r7_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> (flags == 5'd0 && code_o == 5'd0));
  a_r11_valid_follows_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o == d_req);
  a_r1_feature_gate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (d_req && !d_feat) |-> undef_o);
  a_r2_level0_undef: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (d_req && d_el == 2'd0) |-> undef_o);
  a_r8_level3_result: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (d_req && d_el == 2'd3) |-> (undef_o || phys_o));
  a_r6_no_level2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (d_req && !d_l2on) |-> (!trap_el2_o && !virt_o));
  a_r5_no_level3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (d_req && !d_l3) |-> !trap_el3_o);
  a_r9_syndrome_on_trap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_el2_o |-> syndrome_o == TRAP_SYND);
  a_r9_syndrome_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !trap_el2_o |-> syndrome_o == 8'h00);

endmodule

bind pmr_access_router pmr_access_router_chk #(
  .REG_OUT  (REG_OUT),
  .TRAP_SYND(TRAP_SYND)
) i_chk (.*);

// File: tb/test_pmr_access_router.sv
module test_pmr_access_router;
  localparam time CLK_PERIOD = 10ns;

  typedef struct packed {
    logic req; logic [1:0] el;
    logic a32, irqif, h2, h3, en2, a32_3, s1, s2, s3;
    logic grp, cmn, f2, i2, f3, i3, dprio, dund, mon;
  } stim_t;

  logic clk = 1'b0, rst_ni = 1'b0;
  stim_t st;
  logic valid_o, undef_o, trap_el2_o, trap_el3_o, virt_o, phys_o;
  logic [4:0] code_o;
  logic [7:0] syndrome_o;
  int total = 0, bad = 0;
  bit done = 0;
  logic [13:0] exp_q;
  string exp_tag;

  always #(CLK_PERIOD/2) clk = ~clk;

  pmr_access_router i_pmr_access_router (
    .clk_i(clk), .rst_ni(rst_ni), .req_i(st.req), .el_i(st.el),
    .has_a32_el1_i(st.a32), .has_irq_if_i(st.irqif), .has_el2_i(st.h2),
    .has_el3_i(st.h3), .el2_en_i(st.en2), .el3_a32_i(st.a32_3),
    .sre_el1_i(st.s1), .sre_el2_i(st.s2), .sre_el3_i(st.s3),
    .l2_grp_trap_i(st.grp), .l2_cmn_trap_i(st.cmn),
    .l2_fiq_route_i(st.f2), .l2_irq_route_i(st.i2),
    .l3_fiq_route_i(st.f3), .l3_irq_route_i(st.i3),
    .dbg_undef_prio_i(st.dprio), .dbg_undef_i(st.dund), .monitor_i(st.mon),
    .valid_o(valid_o), .undef_o(undef_o), .trap_el2_o(trap_el2_o),
    .trap_el3_o(trap_el3_o), .virt_o(virt_o), .phys_o(phys_o),
    .code_o(code_o), .syndrome_o(syndrome_o)
  );

  // outcome index: 0 phys, 1 virt, 2 trap L3, 3 trap L2, 4 undef, -1 none
  function automatic int ref_out(stim_t s);
    bit l2on, r3;
    if (!s.req) return -1;
    if (!s.a32 || !s.irqif) return 4;
    if (s.el == 2'd0) return 4;
    if (s.el == 2'd3) return s.s3 ? 0 : 4;
    l2on = s.h2 && s.en2;
    r3 = s.h3 && s.f3 && s.i3 && !(s.a32_3 && s.mon);
    if (r3 && s.dprio) return 4;
    if (s.el == 2'd1) begin
      if (l2on && s.grp) return 3;
      if (!s.s1) return 4;
      if (l2on && s.cmn) return 3;
      if (l2on && (s.f2 || s.i2)) return 1;
    end else if (!s.s2) return 4;
    if (r3) return s.dund ? 4 : 2;
    return 0;
  endfunction

  function automatic string tag_of(stim_t s);
    if (!s.req) return "R7";
    if (!s.a32 || !s.irqif) return "R1";
    case (s.el)
      2'd0: return "R2";
      2'd1: return "R3";
      2'd2: return "R10";
      default: return "R8";
    endcase
  endfunction

  function automatic logic [13:0] exp_of(stim_t s);
    int o = ref_out(s);
    logic [4:0] c = (o < 0) ? 5'd0 : (5'd1 << o);
    return {s.req, c, (o == 3) ? 8'h03 : 8'h00};
  endfunction

  task automatic chk(string tag, logic [13:0] act, logic [13:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // check the previous request's result (R11: one clock later), then drive next
  task automatic step(stim_t s);
    @(negedge clk);
    chk({exp_tag, "/R11"}, {valid_o, code_o, syndrome_o}, exp_q);
    chk("R7", {4'd0, valid_o, undef_o, trap_el2_o, trap_el3_o, virt_o, phys_o, syndrome_o},
        {4'd0, exp_q[13], exp_q[12:8], exp_q[7:0]});
    chk("R9", {6'd0, syndrome_o}, {6'd0, (exp_q[11] ? 8'h03 : 8'h00)});
    st = s;
    exp_q = exp_of(s);
    exp_tag = tag_of(s);
  endtask

  function automatic stim_t base(logic [1:0] el);
    stim_t s = '0;
    s.req = 1; s.el = el; s.a32 = 1; s.irqif = 1; s.h2 = 1; s.h3 = 1; s.en2 = 1;
    s.s1 = 1; s.s2 = 1; s.s3 = 1;
    return s;
  endfunction

  initial begin
    stim_t s;
    st = '0; exp_q = '0; exp_tag = "R7";
    repeat (3) @(negedge clk);
    chk("R11 reset", {valid_o, code_o, syndrome_o}, 14'd0);
    rst_ni = 1'b1;

    s = base(2'd1); step(s);                               // R3 physical
    s = base(2'd1); s.a32 = 0; step(s);                    // R1
    s = base(2'd2); s.irqif = 0; step(s);                  // R1
    s = base(2'd0); step(s);                               // R2
    s = base(2'd1); s.grp = 1; s.s1 = 0; step(s);          // R3 group trap beats enable
    s = base(2'd1); s.s1 = 0; s.cmn = 1; step(s);          // R3 enable beats common trap
    s = base(2'd1); s.cmn = 1; s.f2 = 1; step(s);          // R3 common trap
    s = base(2'd1); s.i2 = 1; s.f3 = 1; s.i3 = 1; step(s); // R3 virtual beats L3 trap
    s = base(2'd1); s.f3 = 1; s.i3 = 1; step(s);           // R4 trap L3
    s = base(2'd1); s.f3 = 1; s.i3 = 1; s.dprio = 1; s.grp = 1; step(s); // R3 prio undef
    s = base(2'd1); s.f3 = 1; s.i3 = 1; s.dund = 1; step(s); // R4 trap->undef
    s = base(2'd1); s.f3 = 1; s.i3 = 1; s.a32_3 = 1; s.mon = 1; step(s); // R4 monitor
    s = base(2'd1); s.f3 = 1; s.i3 = 0; step(s);           // R4 one bit only
    s = base(2'd1); s.h3 = 0; s.f3 = 1; s.i3 = 1; s.dprio = 1; step(s); // R5
    s = base(2'd1); s.h2 = 0; s.grp = 1; s.f2 = 1; step(s); // R6
    s = base(2'd1); s.en2 = 0; s.cmn = 1; s.i2 = 1; step(s); // R6
    s = base(2'd2); s.s2 = 0; step(s);                     // R10
    s = base(2'd2); s.f3 = 1; s.i3 = 1; s.grp = 1; step(s); // R10 trap L3
    s = base(2'd2); s.s2 = 0; s.f3 = 1; s.i3 = 1; s.dprio = 1; step(s); // R10
    s = base(2'd3); s.s3 = 0; step(s);                     // R8
    s = base(2'd3); s.f3 = 1; s.i3 = 1; s.dprio = 1; s.grp = 1; step(s); // R8
    s = '0; step(s);                                       // R7 idle
    for (int i = 0; i < 3000; i++) begin
      s = stim_t'({$urandom, $urandom});
      s.a32 = ($urandom_range(7) != 0);
      s.irqif = ($urandom_range(7) != 0);
      s.req = ($urandom_range(5) != 0);
      step(s);
    end
    s = '0; step(s); step(s);
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule